// File: doc/BRIEF.md
# Host Command Vector Handshake Register

This block sits between an external host bus and an embedded processor core. It lets the host ask the core to run one of up to 128 vectored interrupt routines. The host writes a single byte. The low seven bits select the vector and the top bit raises a command request. While the request is set, the block shows a pending flag to the core and presents the matching interrupt address, which is the vector number doubled.

When the core takes the interrupt, it pulses an acknowledge. The block then drops the request. The host polls the request bit in the read data to learn when its command has been accepted. While a command is outstanding, the register is locked against further host writes, so the vector the core is about to fetch cannot change under it.

A hardware reset (asynchronous, active low) returns the register to its default state, and so does a synchronous clear input that serves the software, individual and stop reset cases. In the default state the vector field is nonzero.

Top module: `hcv_ctrl`

## Requirements
- R1: After hardware reset, host_rdata reads 0x32 (request bit 7 clear, vector 0x32), cmd_pend is 0 and cmd_addr is 0x64.
- R2: A cycle with soft_clr high reloads the vector field to 0x32 and clears the request bit, even if a command is outstanding. It takes priority over a host write and over an acknowledge.
- R3: When the request bit is clear, a host write (host_we high) loads host_wdata[6:0] into the vector field and host_wdata[7] into the request bit at the same clock edge.
- R4: cmd_addr always equals the current vector field shifted left by one: bit 0 is 0 and bits 7:1 hold the vector.
- R5: cmd_pend is 1 exactly when the request bit is set and core_ack is low.
- R6: core_ack high while the request bit is set drops cmd_pend in that same cycle and clears the request bit at the next clock edge. The vector field is left unchanged.
- R7: A host write while the request bit is set is ignored. Neither the vector nor the request bit changes, and cmd_addr keeps its value.
- R8: A host write with bit 7 = 0 while the request bit is clear updates the vector but leaves cmd_pend at 0.
- R9: host_rdata reads back {request bit, vector field} at all times.
- R10: core_ack while the request bit is clear has no effect on the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_clr | input | 1 | Synchronous reset request for the software, individual and stop reset cases |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte: bit 7 is the request, bits 6:0 are the vector |
| host_rdata | output | 8 | Host read-back of request bit and vector |
| core_ack | input | 1 | Core acknowledge of the host command interrupt |
| cmd_pend | output | 1 | Host-command-pending flag toward the core |
| cmd_addr | output | 8 | Interrupt address, which is the vector doubled |

## Verification
The bench builds the block with its default parameters: a seven-bit vector and a reset vector of 0x32. With these values the full vector range, including 0x00 and 0x7F, and the fixed 0x64 reset address are reachable on the ports. Directed sequences cover these cases:
- a write locked out by an outstanding request
- an acknowledge in the same cycle as a write
- a clear that lands on a pending command
- an acknowledge while the register is idle

A long run with random write, acknowledge and clear traffic then compares every output against a behavioural model on every clock.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
  localparam int unsigned HCV_VEC_W_DEF = 7;
  localparam logic [6:0]  HCV_RST_VEC_DEF = 7'h32;

  typedef enum logic [1:0] {
    HCV_OP_HOLD  = 2'd0,
    HCV_OP_LOAD  = 2'd1,
    HCV_OP_ACK   = 2'd2,
    HCV_OP_CLEAR = 2'd3
  } hcv_op_e;
endpackage

// File: rtl/hcv_rst_sync.sv
module hcv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hcv_host_port.sv
module hcv_host_port #(
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned DATA_W = VEC_W + 1
) (
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              req_q,
  output logic              load_en,
  output logic [VEC_W-1:0]  load_vec,
  output logic              load_req
);
  // a write only lands while no command is outstanding
  always_comb begin
    load_en  = host_we && !req_q;
    load_vec = host_wdata[VEC_W-1:0];
    load_req = host_wdata[DATA_W-1];
  end
endmodule

// File: rtl/hcv_core_side.sv
module hcv_core_side #(
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned ADDR_W = VEC_W + 1
) (
  input  logic              req_q,
  input  logic [VEC_W-1:0]  vec_q,
  input  logic              core_ack,
  output logic              ack_clr,
  output logic              cmd_pend,
  output logic [ADDR_W-1:0] cmd_addr
);
  always_comb begin
    ack_clr  = core_ack && req_q;
    cmd_pend = req_q && !core_ack;
    cmd_addr = {vec_q, 1'b0};
  end
endmodule

// File: rtl/hcv_cmd_reg.sv
module hcv_cmd_reg
  import hcv_pkg::*;
#(
  parameter int unsigned      VEC_W   = 7,
  parameter logic [VEC_W-1:0] RST_VEC = 7'h32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             load_en,
  input  logic [VEC_W-1:0] load_vec,
  input  logic             load_req,
  input  logic             ack_clr,
  output logic [VEC_W-1:0] vec_q,
  output logic             req_q
);
  hcv_op_e          op;
  logic [VEC_W-1:0] vec_d;
  logic             req_d;
  logic             reg_en;

  always_comb begin
    if (soft_clr)     op = HCV_OP_CLEAR;
    else if (load_en) op = HCV_OP_LOAD;
    else if (ack_clr) op = HCV_OP_ACK;
    else              op = HCV_OP_HOLD;
  end

  always_comb begin
    vec_d  = vec_q;
    req_d  = req_q;
    reg_en = 1'b1;
    unique case (op)
      HCV_OP_CLEAR: begin vec_d = RST_VEC;  req_d = 1'b0;     end
      HCV_OP_LOAD:  begin vec_d = load_vec; req_d = load_req; end
      HCV_OP_ACK:   begin req_d = 1'b0;                      end
      default:      begin reg_en = 1'b0;                     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= RST_VEC;
      req_q <= 1'b0;
    end else if (reg_en) begin
      vec_q <= vec_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/hcv_ctrl.sv
module hcv_ctrl
  import hcv_pkg::*;
#(
  parameter int unsigned      VEC_W       = HCV_VEC_W_DEF,
  parameter logic [VEC_W-1:0] RST_VEC     = HCV_RST_VEC_DEF,
  parameter int unsigned      SYNC_STAGES = 2,
  localparam int unsigned     DATA_W      = VEC_W + 1,
  localparam int unsigned     ADDR_W      = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              core_ack,
  output logic              cmd_pend,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic             rst_sync_n;
  logic             load_en;
  logic [VEC_W-1:0] load_vec;
  logic             load_req;
  logic             ack_clr;
  logic [VEC_W-1:0] vec_q;
  logic             req_q;

  hcv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hcv_host_port #(.VEC_W(VEC_W)) u_host (
    .host_we(host_we), .host_wdata(host_wdata), .req_q(req_q),
    .load_en(load_en), .load_vec(load_vec), .load_req(load_req)
  );

  hcv_cmd_reg #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .soft_clr(soft_clr),
    .load_en(load_en), .load_vec(load_vec), .load_req(load_req),
    .ack_clr(ack_clr), .vec_q(vec_q), .req_q(req_q)
  );

  hcv_core_side #(.VEC_W(VEC_W)) u_core (
    .req_q(req_q), .vec_q(vec_q), .core_ack(core_ack),
    .ack_clr(ack_clr), .cmd_pend(cmd_pend), .cmd_addr(cmd_addr)
  );

  assign host_rdata = {req_q, vec_q};
endmodule

// File: rtl/hcv_ctrl_chk.sv
module hcv_ctrl_chk #(
  parameter int unsigned      VEC_W   = 7,
  parameter logic [VEC_W-1:0] RST_VEC = 7'h32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             host_we,
  input logic [VEC_W:0]   host_wdata,
  input logic [VEC_W:0]   host_rdata,
  input logic             core_ack,
  input logic             cmd_pend,
  input logic [VEC_W:0]   cmd_addr
);
  p_soft_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> host_rdata == {1'b0, RST_VEC});

  p_write_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && host_we && !host_rdata[VEC_W]) |=> host_rdata == $past(host_wdata));

  p_addr_double_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_addr == {host_rdata[VEC_W-1:0], 1'b0});

  p_pend_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pend == (host_rdata[VEC_W] && !core_ack));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && core_ack && host_rdata[VEC_W]) |=> !host_rdata[VEC_W]);

  p_busy_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && host_we && host_rdata[VEC_W]) |=> $stable(cmd_addr));

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr && !host_we && !host_rdata[VEC_W]) |=> $stable(host_rdata));
endmodule

bind hcv_ctrl hcv_ctrl_chk #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .soft_clr(soft_clr), .host_we(host_we),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .core_ack(core_ack),
  .cmd_pend(cmd_pend), .cmd_addr(cmd_addr)
);

// File: tb/hcv_ctrl_tb.sv
module hcv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_clr;
  logic       host_we;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       core_ack;
  logic       cmd_pend;
  logic [7:0] cmd_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  logic [6:0] m_vec;
  logic       m_req;

  always #2.5 clk = ~clk;

  hcv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .core_ack(core_ack),
    .cmd_pend(cmd_pend), .cmd_addr(cmd_addr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vec = 7'h32; m_req = 1'b0;
    end else if (soft_clr) begin
      m_vec = 7'h32; m_req = 1'b0;
    end else if (host_we && !m_req) begin
      m_vec = host_wdata[6:0]; m_req = host_wdata[7];
    end else if (core_ack && m_req) begin
      m_req = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every output against the model
  task automatic cmp_all();
    chk("R9 rdata", host_rdata, {m_req, m_vec});
    chk("R5 pend", {7'd0, cmd_pend}, {7'd0, m_req && !core_ack});
    chk("R4 addr", cmd_addr, {m_vec, 1'b0});
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic ack, input logic sc);
    @(negedge clk);
    host_we = we; host_wdata = wd; core_ack = ack; soft_clr = sc;
    #1;
    cmp_all();
  endtask

  initial begin
    rst_n = 1'b0; soft_clr = 1'b0; host_we = 1'b0; host_wdata = '0; core_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata", host_rdata, 8'h32);
    chk("R1 addr", cmd_addr, 8'h64);
    chk("R1 pend", {7'd0, cmd_pend}, 8'd0);
    rst_n = 1'b1;
    repeat (4) step(0, 8'h00, 0, 0);

    // R8: vector update without request
    step(1, 8'h15, 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R8 rdata", host_rdata, 8'h15);
    chk("R8 pend", {7'd0, cmd_pend}, 8'd0);

    // R3: vector and request in one write
    step(1, 8'hFF, 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R3 rdata", host_rdata, 8'hFF);
    chk("R4 addr max", cmd_addr, 8'hFE);
    chk("R5 pend", {7'd0, cmd_pend}, 8'd1);

    // R7: locked write
    step(1, 8'h81, 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R7 rdata", host_rdata, 8'hFF);
    chk("R7 addr", cmd_addr, 8'hFE);

    // R6: ack drops pend same cycle, clears request next edge; write in ack cycle ignored
    step(1, 8'h80, 1, 0);
    chk("R6 pend same cycle", {7'd0, cmd_pend}, 8'd0);
    step(0, 8'h00, 0, 0);
    chk("R6 cleared", host_rdata, 8'h7F);

    // R10: ack while idle
    step(0, 8'h00, 1, 0);
    step(0, 8'h00, 0, 0);
    chk("R10 rdata", host_rdata, 8'h7F);

    // R2: clear on pending command, beats a write
    step(1, 8'h80, 0, 0);
    step(0, 8'h00, 0, 0);
    chk("R3 vec zero", cmd_addr, 8'h00);
    step(1, 8'h05, 0, 1);
    step(0, 8'h00, 0, 0);
    chk("R2 rdata", host_rdata, 8'h32);
    chk("R2 addr", cmd_addr, 8'h64);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[15:8], r[2] & r[3], r[4] & r[5] & r[6]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule